// File: doc/BRIEF.md
# Ping-Pong Line Buffer with Bank-Ready Interrupt

The block lets pixel capture and host readout overlap. An 8 KB memory is split into two 4 KB banks. The capture side streams 8-bit pixels into one bank, the write bank. Meanwhile the host reads the other bank, the ready bank, through a simple memory-style read port. The read port has an address, a chip select, an output enable and a 32-bit data bus, and it returns data one cycle after a strobed address.

A bank is full once it has taken six image lines of 640 pixels, which is 3840 bytes, regardless of where its address range ends. When a bank fills, the block does three things: it records that bank as ready, raises a level interrupt and moves capture to the other bank. The interrupt stays high until the host pulses an acknowledge, which hands the bank back to capture. A bank can also fill while the previous one is still unacknowledged. In that case the block raises a sticky overrun flag and drops pixels until the acknowledge arrives. A start-of-frame pulse realigns capture to the first byte of bank 0.

Incoming pixels are packed four at a time into 32-bit memory words. This keeps the memory at 2048 entries.

Top module: `pingpong_line_buf`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `irq`, `overrun`, `rdy_bank` and `rdy_bytes` are all 0, and the first accepted pixel is stored as byte 0 of bank 0.
- R2: Byte n (counted from 0) of a bank's fill is stored in word n/4 of that bank, at bits 8*(n mod 4)+7 down to 8*(n mod 4). Host word address bit 10 selects the bank and bits 9..0 select the word within it.
- R3: `irq` stays low until 3840 bytes have been accepted into the write bank. On the cycle after the 3840th byte, `irq` is 1, `rdy_bank` is the index of the bank that filled and `rdy_bytes` is 3840.
- R4: After a bank is announced, the following pixels are written from byte 0 of the other bank, so the announced bank alternates between 0 and 1.
- R5: `irq` stays high until a cycle with `host_ack` high, and is low on the cycle after that acknowledge.
- R6: When `host_cs` and `host_oe` are both high at a clock edge, `host_rdata` shows the addressed word after that edge. At any other edge `host_rdata` keeps its value.
- R7: If a bank fills while `irq` is high and no acknowledge arrives in that cycle, then `overrun` is set, `rdy_bank` is left unchanged and that fill is not announced. Pixels are then dropped until `host_ack`. After the acknowledge, pixels refill the same bank starting at byte 0.
- R8: Once set, `overrun` stays high until a start-of-frame pulse clears it. An acknowledge alone does not clear it.
- R9: A pixel that arrives in the same cycle as `sof` is stored as byte 0 of bank 0. Any partly packed word and any partial byte count are discarded.
- R10: When `host_ack` and the filling byte of the write bank fall in the same cycle, the acknowledge is applied first. The new bank is announced (`irq` stays 1 and `rdy_bank` changes) and `overrun` does not rise.
- R11: A `host_ack` pulse while `irq` is low changes neither `irq`, nor `overrun`, nor the byte count of the bank being filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse, realigns capture to bank 0 |
| pix_valid | input | 1 | Pixel strobe from the capture side |
| pix_data | input | 8 | Pixel byte |
| host_addr | input | 11 | Host word address, bit 10 is the bank |
| host_cs | input | 1 | Host chip select |
| host_oe | input | 1 | Host output enable |
| host_rdata | output | 32 | Host read data, one-cycle latency |
| host_ack | input | 1 | Host pulse releasing the ready bank |
| irq | output | 1 | Level interrupt, a bank is ready |
| rdy_bank | output | 1 | Index of the ready bank |
| rdy_bytes | output | 13 | Valid bytes in the ready bank, 0 when none |
| overrun | output | 1 | Sticky flag, a bank filled before the previous one was released |

## Verification
The sharpest collision is the host acknowledge landing in the same cycle as the byte that fills the write bank. The acknowledge must win, so that the fill is announced as a fresh ready bank and not counted as an overrun. The bench provokes this by holding the ack back, filling the next bank to one byte short, and then sending the last byte with `host_ack` high in that same cycle. It judges the result from `irq`, `rdy_bank` and `overrun` on the following cycle. A second collision is a start-of-frame that arrives while a pixel is also valid. It is judged by reading back word 0 of bank 0 after a partly packed word had been left in flight.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

    localparam int DEF_LINE_BYTES     = 640;
    localparam int DEF_LINES_PER_BANK = 6;
    localparam int DEF_BANK_BYTES     = 4096;
    localparam int DEF_PIX_W          = 8;
    localparam int DEF_LANES          = 4;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    typedef struct packed {
        logic  pending;
        bank_e ready;
        logic  overrun;
        logic  drop;
    } bank_state_t;

    function automatic bank_e other_bank(bank_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction

endpackage

// File: rtl/ppb_bank_ctl.sv
module ppb_bank_ctl
    import ppb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sof,
    input  logic  fill_done,
    input  logic  host_ack,
    output bank_e wr_bank_now,
    output logic  drop_now,
    output logic  pending,
    output bank_e ready_bank,
    output logic  overrun
);

    bank_state_t st_q, st_d;
    bank_e       wr_q, wr_d;
    logic        pend_eff;

    always_comb begin
        wr_bank_now = sof ? BANK_A : wr_q;
        pend_eff    = st_q.pending & ~host_ack;
        drop_now    = st_q.drop & ~host_ack;
        st_d        = st_q;
        wr_d        = wr_bank_now;
        if (sof) begin
            st_d.overrun = 1'b0;
        end
        if (host_ack) begin
            st_d.pending = 1'b0;
            st_d.drop    = 1'b0;
        end
        if (fill_done) begin
            if (!pend_eff) begin
                st_d.pending = 1'b1;
                st_d.ready   = wr_bank_now;
                wr_d         = other_bank(wr_bank_now);
            end else begin
                st_d.overrun = 1'b1;
                st_d.drop    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            wr_q <= BANK_A;
        end else begin
            st_q <= st_d;
            wr_q <= wr_d;
        end
    end

    assign pending    = st_q.pending;
    assign ready_bank = st_q.ready;
    assign overrun    = st_q.overrun;

endmodule

// File: rtl/ppb_packer.sv
module ppb_packer
    import ppb_pkg::*;
#(
    parameter int PIX_W      = DEF_PIX_W,
    parameter int LANES      = DEF_LANES,
    parameter int BANK_BYTES = DEF_BANK_BYTES,
    parameter int FILL_BYTES = DEF_LINE_BYTES * DEF_LINES_PER_BANK
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sof,
    input  logic                          pix_valid,
    input  logic [PIX_W-1:0]              pix_data,
    input  logic                          drop_now,
    input  bank_e                         wr_bank_now,
    output logic                          mem_we,
    output logic [$clog2(BANK_BYTES/LANES):0] mem_waddr,
    output logic [PIX_W*LANES-1:0]        mem_wdata,
    output logic                          fill_done
);

    localparam int WORD_W = PIX_W * LANES;
    localparam int LANE_W = $clog2(LANES);
    localparam int CNT_W  = $clog2(BANK_BYTES);

    logic [CNT_W-1:0]  cnt_q, cnt_now;
    logic [WORD_W-1:0] pack_q;
    logic [LANE_W-1:0] lane;
    logic              accept;

    always_comb begin
        cnt_now   = sof ? '0 : cnt_q;
        lane      = cnt_now[LANE_W-1:0];
        accept    = pix_valid & ~drop_now;
        fill_done = accept && (cnt_now == CNT_W'(FILL_BYTES - 1));
        mem_we    = accept && (lane == LANE_W'(LANES - 1));
        mem_waddr = {wr_bank_now, cnt_now[CNT_W-1:LANE_W]};
        mem_wdata = {pix_data, pack_q[WORD_W-PIX_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pack_q <= '0;
        end else if (accept) begin
            pack_q[int'(lane)*PIX_W +: PIX_W] <= pix_data;
            cnt_q <= fill_done ? '0 : cnt_now + 1'b1;
        end else if (sof) begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/ppb_dpram.sv
module ppb_dpram #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 2 ** ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/pingpong_line_buf.sv
module pingpong_line_buf
    import ppb_pkg::*;
#(
    parameter int LINE_BYTES     = DEF_LINE_BYTES,
    parameter int LINES_PER_BANK = DEF_LINES_PER_BANK,
    parameter int BANK_BYTES     = DEF_BANK_BYTES,
    parameter int PIX_W          = DEF_PIX_W,
    parameter int LANES          = DEF_LANES
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   sof,
    input  logic                                   pix_valid,
    input  logic [PIX_W-1:0]                       pix_data,
    input  logic [$clog2(BANK_BYTES/LANES):0]      host_addr,
    input  logic                                   host_cs,
    input  logic                                   host_oe,
    output logic [PIX_W*LANES-1:0]                 host_rdata,
    input  logic                                   host_ack,
    output logic                                   irq,
    output logic                                   rdy_bank,
    output logic [$clog2(BANK_BYTES+1)-1:0]        rdy_bytes,
    output logic                                   overrun
);

    localparam int FILL_BYTES = LINE_BYTES * LINES_PER_BANK;
    localparam int WORD_W     = PIX_W * LANES;
    localparam int ADDR_W     = $clog2(BANK_BYTES / LANES) + 1;
    localparam int RB_W       = $clog2(BANK_BYTES + 1);

    bank_e             wr_bank_now;
    bank_e             ready_bank;
    logic              drop_now;
    logic              fill_done;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;

    ppb_bank_ctl u_bank (
        .clk        (clk),
        .rst        (rst),
        .sof        (sof),
        .fill_done  (fill_done),
        .host_ack   (host_ack),
        .wr_bank_now(wr_bank_now),
        .drop_now   (drop_now),
        .pending    (irq),
        .ready_bank (ready_bank),
        .overrun    (overrun)
    );

    ppb_packer #(
        .PIX_W     (PIX_W),
        .LANES     (LANES),
        .BANK_BYTES(BANK_BYTES),
        .FILL_BYTES(FILL_BYTES)
    ) u_pack (
        .clk        (clk),
        .rst        (rst),
        .sof        (sof),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .drop_now   (drop_now),
        .wr_bank_now(wr_bank_now),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .fill_done  (fill_done)
    );

    ppb_dpram #(
        .WORD_W(WORD_W),
        .ADDR_W(ADDR_W)
    ) u_mem (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .re   (host_cs & host_oe),
        .raddr(host_addr),
        .rdata(host_rdata)
    );

    assign rdy_bank  = ready_bank;
    assign rdy_bytes = irq ? RB_W'(FILL_BYTES) : '0;

endmodule

// File: rtl/ppb_checker.sv
module ppb_checker (
    input logic clk,
    input logic rst,
    input logic sof,
    input logic host_ack,
    input logic irq,
    input logic overrun,
    input logic rdy_bank,
    input logic wr_bank,
    input logic fill_done,
    input logic drop_q,
    input logic mem_we
);

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        irq && !host_ack |=> irq); // R5

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        irq && host_ack && !fill_done |=> !irq); // R5

    AST_ACK_WINS: assert property (@(posedge clk) disable iff (rst)
        irq && host_ack && fill_done |=> irq && (rdy_bank != $past(rdy_bank))); // R10

    AST_SWAP_OTHER: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (wr_bank != rdy_bank)); // R4

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun && !sof |=> overrun); // R8

    AST_OVR_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> irq); // R7

    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        drop_q && !host_ack |-> !mem_we); // R7

endmodule

bind pingpong_line_buf ppb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .sof      (sof),
    .host_ack (host_ack),
    .irq      (irq),
    .overrun  (overrun),
    .rdy_bank (rdy_bank),
    .wr_bank  (u_bank.wr_q),
    .fill_done(fill_done),
    .drop_q   (u_bank.st_q.drop),
    .mem_we   (mem_we)
);

// File: tb/pingpong_line_buf_test.sv
module pingpong_line_buf_test;

    localparam int FILL = 640 * 6;
    localparam int BW   = 1024;
    localparam int AW   = 11;
    localparam int WW   = 32;
    localparam int RBW  = 13;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           sof = 1'b0;
    logic           pix_valid = 1'b0;
    logic [7:0]     pix_data = '0;
    logic [AW-1:0]  host_addr = '0;
    logic           host_cs = 1'b0;
    logic           host_oe = 1'b0;
    logic [WW-1:0]  host_rdata;
    logic           host_ack = 1'b0;
    logic           irq;
    logic           rdy_bank;
    logic [RBW-1:0] rdy_bytes;
    logic           overrun;

    always #4 clk = ~clk;

    pingpong_line_buf uut (
        .clk(clk), .rst(rst), .sof(sof), .pix_valid(pix_valid), .pix_data(pix_data),
        .host_addr(host_addr), .host_cs(host_cs), .host_oe(host_oe),
        .host_rdata(host_rdata), .host_ack(host_ack), .irq(irq),
        .rdy_bank(rdy_bank), .rdy_bytes(rdy_bytes), .overrun(overrun)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int seq    = 0;

    // requirement-level model
    logic [WW-1:0] exp_word [0:2*BW-1];
    int m_bank = 0, m_cnt = 0, m_rdy = 0;
    bit m_pend = 0, m_drop = 0, m_ovr = 0;

    // scoreboard queues
    logic [WW-1:0] rd_exp[$];
    string         rd_tag[$];
    logic [WW-1:0] last_rd = '0;
    bit            rd_armed = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic model_step(bit v, logic [7:0] d, bit s, bit a);
        bit pend_e, drop_e;
        int idx;
        if (s) begin m_bank = 0; m_cnt = 0; m_ovr = 0; end
        pend_e = m_pend && !a;
        drop_e = m_drop && !a;
        if (a) begin m_pend = 0; m_drop = 0; end
        if (v && !drop_e) begin
            idx = m_bank * BW + m_cnt / 4;
            exp_word[idx][(m_cnt % 4) * 8 +: 8] = d;
            if (m_cnt == FILL - 1) begin
                m_cnt = 0;
                if (!pend_e) begin m_pend = 1; m_rdy = m_bank; m_bank = 1 - m_bank; end
                else begin m_ovr = 1; m_drop = 1; end
            end else begin
                m_cnt++;
            end
        end
    endtask

    task automatic push(int n, bit with_sof = 0, bit ack_last = 0);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'((seq * 37 + 11) ^ (seq >> 8));
            seq++;
            pix_valid = 1'b1;
            pix_data  = d;
            sof       = with_sof && (i == 0);
            host_ack  = ack_last && (i == n - 1);
            model_step(1'b1, d, sof, host_ack);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        sof       = 1'b0;
        host_ack  = 1'b0;
    endtask

    task automatic ack_pulse();
        host_ack = 1'b1;
        model_step(1'b0, 8'h00, 1'b0, 1'b1);
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    task automatic sof_pulse();
        sof = 1'b1;
        model_step(1'b0, 8'h00, 1'b1, 1'b0);
        @(negedge clk);
        sof = 1'b0;
    endtask

    task automatic host_read(int addr, string tag);
        host_cs   = 1'b1;
        host_oe   = 1'b1;
        host_addr = AW'(addr);
        rd_exp.push_back(exp_word[addr]);
        rd_tag.push_back(tag);
        @(negedge clk);
        host_cs = 1'b0;
        host_oe = 1'b0;
    endtask

    task automatic check_status(string req);
        check({req, " irq"}, 32'(irq), 32'(m_pend));
        check({req, " overrun"}, 32'(overrun), 32'(m_ovr));
        if (m_pend) check({req, " rdy_bank"}, 32'(rdy_bank), 32'(m_rdy));
        check({req, " rdy_bytes"}, 32'(rdy_bytes), m_pend ? 32'(FILL) : 32'd0);
    endtask

    // monitor: a strobe sampled at an edge expects data at the next falling edge
    always @(posedge clk) rd_armed <= host_cs && host_oe;

    always @(negedge clk) begin
        if (rd_armed) begin
            if (rd_exp.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R6: actual unexpected read data expected no read");
            end else begin
                logic [WW-1:0] e;
                string t;
                e = rd_exp.pop_front();
                t = rd_tag.pop_front();
                last_rd = e;
                check(t, host_rdata, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual still running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2 * BW; i++) exp_word[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 irq in reset", 32'(irq), 0);
        check("R1 overrun in reset", 32'(overrun), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq", 32'(irq), 0);
        check("R1 rdy_bank", 32'(rdy_bank), 0);
        check("R1 rdy_bytes", 32'(rdy_bytes), 0);
        check("R1 overrun", 32'(overrun), 0);

        // R3: one byte short keeps irq low
        push(FILL - 1);
        check("R3 no irq before quota", 32'(irq), 0);
        push(1);
        check("R3 irq", 32'(irq), 1);
        check("R3 rdy_bank", 32'(rdy_bank), 0);
        check("R3 rdy_bytes", 32'(rdy_bytes), FILL);

        // R1 R2: bank 0 layout, first byte at bank 0 word 0 lane 0
        host_read(0, "R1 R2 bank0 word0");
        host_read(1, "R2 bank0 word1");
        host_read(FILL / 4 - 1, "R2 bank0 last word");
        // R6: chip select without output enable leaves data unchanged
        host_cs = 1'b1;
        host_addr = AW'(5);
        @(negedge clk);
        host_cs = 1'b0;
        @(negedge clk);
        check("R6 hold without oe", host_rdata, last_rd);

        // R4: next pixels land at the start of bank 1
        push(8);
        host_read(BW + 0, "R4 bank1 word0");
        host_read(BW + 1, "R4 bank1 word1");

        // R5: level hold, then release
        repeat (5) @(negedge clk);
        check("R5 irq held", 32'(irq), 1);
        ack_pulse();
        check("R5 irq released", 32'(irq), 0);
        check_status("R5");

        // R11: stray acknowledge
        ack_pulse();
        check("R11 irq", 32'(irq), 0);
        check("R11 overrun", 32'(overrun), 0);
        push(FILL - 9);
        check("R11 count unchanged", 32'(irq), 0);
        push(1);
        check("R4 alternation irq", 32'(irq), 1);
        check("R4 alternation rdy_bank", 32'(rdy_bank), 1);

        // R7: fill bank 0 without releasing bank 1
        push(FILL);
        check("R7 overrun", 32'(overrun), 1);
        check("R7 irq", 32'(irq), 1);
        check("R7 rdy_bank kept", 32'(rdy_bank), 1);
        host_read(0, "R7 bank0 word0 refilled");
        push(12);
        ack_pulse();
        check("R8 overrun sticky after ack", 32'(overrun), 1);
        push(4);
        host_read(0, "R7 dropped pixels absent");
        check_status("R7");

        // R8: start of frame clears overrun
        sof_pulse();
        check("R8 overrun cleared", 32'(overrun), 0);

        // R9: partial word in flight, then sof with a pixel
        push(6);
        push(4, 1'b1);
        host_read(0, "R9 sof pixel at byte 0");

        // R10: acknowledge together with the filling byte
        push(FILL - 4);
        check("R10 bank0 ready", 32'(irq), 1);
        push(FILL - 1);
        push(1, 1'b0, 1'b1);
        check("R10 irq", 32'(irq), 1);
        check("R10 rdy_bank", 32'(rdy_bank), 1);
        check("R10 overrun", 32'(overrun), 0);
        check_status("R10");

        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule